// File: doc/BRIEF.md
# Test-Access Instruction Register and Decoder

This block is the instruction path of a boundary-scan test port. A three-bit instruction is shifted in serially on the test clock, then copied into a holding register on the falling clock edge of the update-IR state. The held code is decoded into two things: which data register sits between the test data input and the serial test output, and which control mode the chip's digital pins are in. Normal function, driven from the boundary register, held in clamp, or high impedance.

The block contains the instruction shift stage, the holding register, the decoder, a one-bit bypass register, a 32-bit identification register and the retimed output multiplexer. The TAP state machine is outside the block and supplies one-hot state strobes. The boundary cell chain is also outside the block. It receives gated capture, shift and update enables and returns its serial output on `bsr_so`. The port is a serial scan interface clocked by the test clock. A valid/ready handshake does not fit it, so there is no back-pressure: every test clock edge in a shift state moves one bit.

Top module: `tap_ir_path`

## Requirements
- R1: While `trst_n` is low, the held instruction is IDCODE (001), so `dr_sel` = 01. The mode outputs are low, `tdo_oe` and `tdo` are low, and the bypass register is 0.
- R2: In capture-IR, the shift stage loads 001. The following shift-IR cycles present it on `tdo` least-significant bit first: 1, 0, 0.
- R3: In shift-IR, each rising `tck` edge moves the three-bit shift stage one place toward `tdo`, with `tdi` entering at the most-significant end. After three shifts, the first bit shifted in is the least-significant bit.
- R4: The held instruction changes only on a falling `tck` edge while `st_update_ir` is high. Shifting alone leaves `dr_sel` and the mode outputs unchanged.
- R5: `dr_sel` encodes the routed register as 00 bypass, 01 identification and 10 boundary. EXTEST (000) and SAMPLE/PRELOAD (010) give 10. IDCODE (001) gives 01. CLAMP (011), HIGHZ (100) and BYPASS (111) give 00.
- R6: The unused codes 101 and 110 act as BYPASS: `dr_sel` = 00 and every mode output is low.
- R7: Under EXTEST, `mode_drive` is 1 while `mode_clamp` and `mode_hiz` are 0. The boundary enables `bsr_capture_en`, `bsr_shift_en` and `bsr_update_en` follow the capture-DR, shift-DR and update-DR strobes.
- R8: Under CLAMP, `mode_drive` and `mode_clamp` are both 1 and `mode_hiz` is 0. `bsr_update_en` stays low in update-DR, so the boundary outputs cannot change.
- R9: Under HIGHZ, `mode_hiz` is 1 and `mode_drive` and `mode_clamp` are 0.
- R10: When bypass is routed, capture-DR loads 0. In shift-DR, `tdo` repeats `tdi` delayed by one shift.
- R11: When the identification register is routed, capture-DR loads `ID_VALUE`. Shift-DR emits it least-significant bit first over 32 shifts.
- R12: `tdo` and `tdo_oe` update only on the falling `tck` edge. `tdo_oe` is 1 exactly when the state in force at that edge is shift-IR or shift-DR. Otherwise `tdo` is 0.
- R13: When the boundary register is routed, `tdo` during shift-DR carries the `bsr_so` value present at that falling edge. Under any other routing, the boundary enables stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| st_capture_ir | input | 1 | TAP state strobe: capture-IR |
| st_shift_ir | input | 1 | TAP state strobe: shift-IR |
| st_update_ir | input | 1 | TAP state strobe: update-IR |
| st_capture_dr | input | 1 | TAP state strobe: capture-DR |
| st_shift_dr | input | 1 | TAP state strobe: shift-DR |
| st_update_dr | input | 1 | TAP state strobe: update-DR |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, changes on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| dr_sel | output | 2 | Routed register: 00 bypass, 01 identification, 10 boundary |
| mode_drive | output | 1 | Pins driven from boundary parallel outputs |
| mode_clamp | output | 1 | Boundary parallel outputs frozen |
| mode_hiz | output | 1 | Pins placed in high impedance |
| bsr_capture_en | output | 1 | Boundary chain capture enable |
| bsr_shift_en | output | 1 | Boundary chain shift enable |
| bsr_update_en | output | 1 | Boundary chain update enable |

## Verification
The bench targets the unused codes 101 and 110. A decoder with no default would route an undefined register or switch a pin mode for them. It checks that the capture-IR pattern comes out least-significant bit first, and that the held instruction stays put through shifting. A design that latched on the rising edge, or that left out the update-IR condition, would change routing in the middle of a shift. Under CLAMP it watches update-DR, because a design that passed the update strobe through would let the clamped outputs move. It also checks the one-shift delay of bypass, where a design that cleared or skipped the stage would give a pattern shifted by one place. Finally, it checks that a second reset in mid-test returns the block from HIGHZ to IDCODE.

// File: rtl/tap_ir_pkg.sv
`timescale 1ns/1ps
package tap_ir_pkg;
  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    SEL_BYP = 2'b00,
    SEL_IDR = 2'b01,
    SEL_BSR = 2'b10
  } sel_e;

  typedef struct packed {
    sel_e sel;
    logic drive;
    logic clamp;
    logic hiz;
  } dec_t;
endpackage

// File: rtl/tap_ir_reg.sv
`timescale 1ns/1ps
module tap_ir_reg #(
  parameter int W = 3,
  parameter logic [W-1:0] CAP_PAT = '0,
  parameter logic [W-1:0] RST_OP = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         cap,
  input  logic         shift,
  input  logic         upd,
  output logic         sh_lsb,
  output logic [W-1:0] cur
);
  logic [W-1:0] ir_sh;

  // serial stage, rising edge
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ir_sh <= CAP_PAT;
    else if (cap)    ir_sh <= CAP_PAT;
    else if (shift)  ir_sh <= {tdi, ir_sh[W-1:1]};
  end

  // holding stage, falling edge of update-IR
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)   cur <= RST_OP;
    else if (upd)  cur <= ir_sh;
  end

  assign sh_lsb = ir_sh[0];
endmodule

// File: rtl/tap_ir_decode.sv
`timescale 1ns/1ps
module tap_ir_decode
  import tap_ir_pkg::*;
(
  input  logic [IR_W-1:0] op,
  output dec_t            dec
);
  always_comb begin
    dec = '{sel: SEL_BYP, drive: 1'b0, clamp: 1'b0, hiz: 1'b0};
    case (op)
      OP_EXTEST: begin dec.sel = SEL_BSR; dec.drive = 1'b1; end
      OP_IDCODE: dec.sel = SEL_IDR;
      OP_SAMPLE: dec.sel = SEL_BSR;
      OP_CLAMP:  begin dec.drive = 1'b1; dec.clamp = 1'b1; end
      OP_HIGHZ:  dec.hiz = 1'b1;
      default:   dec.sel = SEL_BYP;
    endcase
  end
endmodule

// File: rtl/tap_dr_local.sv
`timescale 1ns/1ps
module tap_dr_local #(
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic cap,
  input  logic shift,
  input  logic use_byp,
  input  logic use_idr,
  output logic byp_so,
  output logic id_so
);
  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 byp_q <= 1'b0;
    else if (cap && use_byp)     byp_q <= 1'b0;
    else if (shift && use_byp)   byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 id_q <= ID_VALUE;
    else if (cap && use_idr)     id_q <= ID_VALUE;
    else if (shift && use_idr)   id_q <= {tdi, id_q[ID_W-1:1]};
  end

  assign byp_so = byp_q;
  assign id_so  = id_q[0];
endmodule

// File: rtl/tap_tdo_mux.sv
`timescale 1ns/1ps
module tap_tdo_mux
  import tap_ir_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic shift_ir,
  input  logic shift_dr,
  input  sel_e sel,
  input  logic ir_so,
  input  logic byp_so,
  input  logic id_so,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe
);
  logic dr_bit;

  always_comb begin
    case (sel)
      SEL_IDR: dr_bit = id_so;
      SEL_BSR: dr_bit = bsr_so;
      default: dr_bit = byp_so;
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift_ir | shift_dr;
      tdo    <= shift_ir ? ir_so : (shift_dr ? dr_bit : 1'b0);
    end
  end
endmodule

// File: rtl/tap_ir_path.sv
`timescale 1ns/1ps
module tap_ir_path
  import tap_ir_pkg::*;
#(
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h2B7A_4E93
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  logic       st_capture_ir,
  input  logic       st_shift_ir,
  input  logic       st_update_ir,
  input  logic       st_capture_dr,
  input  logic       st_shift_dr,
  input  logic       st_update_dr,
  input  logic       bsr_so,
  output logic       tdo,
  output logic       tdo_oe,
  output logic [1:0] dr_sel,
  output logic       mode_drive,
  output logic       mode_clamp,
  output logic       mode_hiz,
  output logic       bsr_capture_en,
  output logic       bsr_shift_en,
  output logic       bsr_update_en
);
  logic [IR_W-1:0] ir_cur;
  logic            ir_so, byp_so, id_so;
  dec_t            dec;
  logic            to_bsr;

  tap_ir_reg #(.W(IR_W), .CAP_PAT(IR_CAPTURE), .RST_OP(OP_IDCODE)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(st_capture_ir), .shift(st_shift_ir), .upd(st_update_ir),
    .sh_lsb(ir_so), .cur(ir_cur)
  );

  tap_ir_decode u_dec (.op(ir_cur), .dec(dec));

  tap_dr_local #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(st_capture_dr), .shift(st_shift_dr),
    .use_byp(dec.sel == SEL_BYP), .use_idr(dec.sel == SEL_IDR),
    .byp_so(byp_so), .id_so(id_so)
  );

  tap_tdo_mux u_tdo (
    .tck(tck), .trst_n(trst_n),
    .shift_ir(st_shift_ir), .shift_dr(st_shift_dr), .sel(dec.sel),
    .ir_so(ir_so), .byp_so(byp_so), .id_so(id_so), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe)
  );

  assign to_bsr         = (dec.sel == SEL_BSR);
  assign dr_sel         = dec.sel;
  assign mode_drive     = dec.drive;
  assign mode_clamp     = dec.clamp;
  assign mode_hiz       = dec.hiz;
  assign bsr_capture_en = st_capture_dr & to_bsr;
  assign bsr_shift_en   = st_shift_dr & to_bsr;
  assign bsr_update_en  = st_update_dr & to_bsr;
endmodule

// File: rtl/tap_ir_path_chk.sv
`timescale 1ns/1ps
module tap_ir_path_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       st_update_ir,
  input logic       st_shift_ir,
  input logic       st_shift_dr,
  input logic [2:0] ir_cur,
  input logic [1:0] dr_sel,
  input logic       mode_drive,
  input logic       mode_clamp,
  input logic       mode_hiz,
  input logic       tdo_oe,
  input logic       bsr_update_en
);
  a_r4_hold_between_updates: assert property (@(posedge tck) disable iff (!trst_n)
    !st_update_ir |-> $stable(ir_cur));

  a_r12_oe_only_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st_shift_ir || st_shift_dr));

  a_r8_clamp_blocks_update: assert property (@(posedge tck) disable iff (!trst_n)
    mode_clamp |-> (!bsr_update_en && mode_drive));

  a_r9_hiz_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    mode_hiz |-> (!mode_drive && !mode_clamp && dr_sel == 2'b00));

  a_r5_sel_legal: assert property (@(posedge tck) disable iff (!trst_n)
    dr_sel != 2'b11);
endmodule

bind tap_ir_path tap_ir_path_chk u_chk (
  .tck(tck), .trst_n(trst_n), .st_update_ir(st_update_ir),
  .st_shift_ir(st_shift_ir), .st_shift_dr(st_shift_dr), .ir_cur(ir_cur),
  .dr_sel(dr_sel), .mode_drive(mode_drive), .mode_clamp(mode_clamp),
  .mode_hiz(mode_hiz), .tdo_oe(tdo_oe), .bsr_update_en(bsr_update_en)
);

// File: tb/test_tap_ir_path.sv
`timescale 1ns/1ps
module test_tap_ir_path;
  localparam logic [31:0] IDV = 32'h2B7A_4E93;
  localparam logic [5:0] S_IDLE = 6'b000000, S_CIR = 6'b100000, S_SIR = 6'b010000,
                         S_UIR = 6'b001000, S_CDR = 6'b000100, S_SDR = 6'b000010,
                         S_UDR = 6'b000001;

  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0, bsr_so = 1'b0;
  logic cap_ir = 0, sh_ir = 0, up_ir = 0, cap_dr = 0, sh_dr = 0, up_dr = 0;
  logic tdo, tdo_oe, mode_drive, mode_clamp, mode_hiz;
  logic bsr_capture_en, bsr_shift_en, bsr_update_en;
  logic [1:0] dr_sel;

  int nchk = 0, nfail = 0;
  logic l_tdo, l_oe, l_cap, l_shf, l_upd;
  logic [1:0] l_sel;
  logic [31:0] dr_out;
  logic cap_seen, upd_seen, shf_seen;

  always #2 tck = ~tck;

  tap_ir_path i_tap_ir_path (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .st_capture_ir(cap_ir), .st_shift_ir(sh_ir), .st_update_ir(up_ir),
    .st_capture_dr(cap_dr), .st_shift_dr(sh_dr), .st_update_dr(up_dr),
    .bsr_so(bsr_so), .tdo(tdo), .tdo_oe(tdo_oe), .dr_sel(dr_sel),
    .mode_drive(mode_drive), .mode_clamp(mode_clamp), .mode_hiz(mode_hiz),
    .bsr_capture_en(bsr_capture_en), .bsr_shift_en(bsr_shift_en),
    .bsr_update_en(bsr_update_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a state for one test clock; sample after the falling edge
  task automatic tick(input logic [5:0] st, input logic din, input logic bso);
    {cap_ir, sh_ir, up_ir, cap_dr, sh_dr, up_dr} = st;
    tdi = din; bsr_so = bso;
    @(negedge tck); #0.5;
    l_tdo = tdo; l_oe = tdo_oe; l_sel = dr_sel;
    l_cap = bsr_capture_en; l_shf = bsr_shift_en; l_upd = bsr_update_en;
    @(posedge tck); #0.5;
  endtask

  task automatic load_ir(input logic [2:0] code, input logic [1:0] old_sel);
    tick(S_CIR, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick(S_SIR, code[i], 1'b0);
      chk("R2 capture pattern bit", {31'd0, l_tdo}, {31'd0, (i == 0)});
      chk("R12 oe in shift-IR", {31'd0, l_oe}, 32'd1);
      chk("R4 sel held while shifting", {30'd0, l_sel}, {30'd0, old_sel});
    end
    tick(S_IDLE, 1'b0, 1'b0);
    chk("R12 oe off outside shift", {30'd0, l_oe, l_tdo}, 32'd0);
    tick(S_UIR, 1'b0, 1'b0);
  endtask

  // capture-DR, n shifts, update-DR; bsr_so driven as inverse of tdi
  task automatic run_dr(input int n, input logic [31:0] din);
    dr_out = '0;
    tick(S_CDR, 1'b0, 1'b0); cap_seen = l_cap;
    shf_seen = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick(S_SDR, din[i], ~din[i]);
      dr_out[i] = l_tdo;
      shf_seen = shf_seen & l_shf;
    end
    tick(S_UDR, 1'b0, 1'b0); upd_seen = l_upd;
    tick(S_IDLE, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    repeat (2) @(posedge tck);
    #0.5;
    chk("R1 reset sel IDCODE", {30'd0, dr_sel}, 32'd1);
    chk("R1 reset modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd0);
    chk("R1 reset tdo", {30'd0, tdo_oe, tdo}, 32'd0);
    trst_n = 1'b1;
    tick(S_SDR, 1'b0, 1'b0);
    chk("R11 reset ident LSB out", {31'd0, l_tdo}, {31'd0, IDV[0]});
    tick(S_IDLE, 1'b0, 1'b0);
    load_ir(3'b111, 2'b01);
    chk("R5 BYPASS sel", {30'd0, l_sel}, 32'd0);
    tick(S_SDR, 1'b1, 1'b0);
    chk("R1 bypass reset to zero", {31'd0, l_tdo}, 32'd0);
    tick(S_SDR, 1'b0, 1'b0);
    chk("R10 bypass one-shift delay", {31'd0, l_tdo}, 32'd1);
    tick(S_IDLE, 1'b0, 1'b0);
  endtask

  task automatic t_bypass;
    logic [31:0] pat = 32'h0000_00B6;
    run_dr(8, pat);
    chk("R10 bypass stream", dr_out, {pat[30:0], 1'b0} & 32'hFF);
    chk("R13 no bsr strobe in bypass", {29'd0, cap_seen, shf_seen, upd_seen}, 32'd0);
  endtask

  task automatic t_idcode;
    load_ir(3'b001, 2'b00);
    chk("R5 IDCODE sel", {30'd0, l_sel}, 32'd1);
    run_dr(32, 32'hFFFF_0000);
    chk("R11 identification value", dr_out, IDV);
  endtask

  task automatic t_sample;
    load_ir(3'b010, 2'b01);
    chk("R5 SAMPLE sel", {30'd0, l_sel}, 32'd2);
    chk("R5 SAMPLE modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd0);
    run_dr(12, 32'h0000_0A5C);
    chk("R13 tdo follows bsr_so", dr_out, (~32'h0000_0A5C) & 32'hFFF);
  endtask

  task automatic t_extest;
    load_ir(3'b000, 2'b10);
    chk("R7 EXTEST sel", {30'd0, l_sel}, 32'd2);
    chk("R7 EXTEST modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd4);
    run_dr(4, 32'h5);
    chk("R7 EXTEST bsr strobes", {29'd0, cap_seen, shf_seen, upd_seen}, 32'd7);
  endtask

  task automatic t_clamp;
    load_ir(3'b011, 2'b10);
    chk("R8 CLAMP sel", {30'd0, l_sel}, 32'd0);
    chk("R8 CLAMP modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd6);
    run_dr(4, 32'h9);
    chk("R8 CLAMP update blocked", {29'd0, cap_seen, shf_seen, upd_seen}, 32'd0);
    chk("R8 CLAMP bypass routed", dr_out, 32'h2);
  endtask

  task automatic t_unused;
    load_ir(3'b101, 2'b00);
    chk("R6 code 101 sel", {30'd0, l_sel}, 32'd0);
    chk("R6 code 101 modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd0);
    run_dr(4, 32'h6);
    chk("R6 code 101 bypass", dr_out, 32'hC & 32'hF);
    load_ir(3'b110, 2'b00);
    chk("R6 code 110 sel", {30'd0, l_sel}, 32'd0);
    chk("R6 code 110 modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd0);
  endtask

  task automatic t_highz_and_reset;
    load_ir(3'b100, 2'b00);
    chk("R9 HIGHZ sel", {30'd0, l_sel}, 32'd0);
    chk("R9 HIGHZ modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd1);
    // R3: shift IDCODE in, update later, check ordering by outcome
    load_ir(3'b001, 2'b00);
    chk("R3 shift order gives IDCODE", {30'd0, l_sel}, 32'd1);
    load_ir(3'b100, 2'b01);
    #0.3 trst_n = 1'b0;
    #1;
    chk("R1 mid-test reset sel", {30'd0, dr_sel}, 32'd1);
    chk("R1 mid-test reset modes", {29'd0, mode_drive, mode_clamp, mode_hiz}, 32'd0);
    @(posedge tck); #0.5 trst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_idcode();
    t_sample();
    t_extest();
    t_clamp();
    t_unused();
    t_highz_and_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    nchk++; nfail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule